// File: doc/BRIEF.md
# Gamma Curve Register Packer

This block keeps a twelve-point gamma curve, each point ten bits wide, and turns it into an ordered burst of byte-wide register writes for a display controller. The upper two bits of every point are gathered four to a byte into three packed registers. The lower eight bits of each point land in a register of their own. The packed registers always go out before any low-byte register.

A one-cycle start pulse begins a burst of fifteen writes on an address/data interface with a valid/ready handshake. That interface feeds a serial register writer further down the chip. After the final write is accepted, a single-cycle done pulse marks the end. A new curve can be loaded through a parallel port while the block is idle. Out of reset the block holds a built-in default curve.

Top module: `gamma_reg_packer`

## Requirements
- R1: After reset, wr_valid_o and done_o are low.
- R2: Out of reset the stored curve is, for points 0 to 11: 105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023.
- R3: Write k for k = 0..2 goes to address 0x11+k and carries bits [9:8] of points 4k to 4k+3.
- R4: In a packed byte, point 4k supplies bits [7:6], point 4k+1 bits [5:4], point 4k+2 bits [3:2] and point 4k+3 bits [1:0].
- R5: Write 3+i for i = 0..11 goes to address 0x14+i and carries bits [7:0] of point i.
- R6: Each start in idle produces exactly 15 accepted writes: the three packed registers first, then the low bytes in ascending point order. wr_valid_o stays high from the first write until the last one is accepted.
- R7: While wr_valid_o is high and wr_ready_i is low, wr_valid_o, wr_addr_o and wr_data_o keep their values into the next cycle.
- R8: done_o is high for exactly the one cycle after the last write is accepted, and wr_valid_o is low in that cycle.
- R9: load_i in idle replaces the stored curve with curve_i, where point i sits in bits [10i+9:10i].
- R10: load_i is ignored while a burst runs or while done_o is high, and the stored curve is unchanged.
- R11: start_i is ignored while a burst runs or while done_o is high; no extra writes follow the done pulse.
- R12: When load_i and start_i are high together in idle, the burst started in that cycle uses the newly loaded curve.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a write burst (idle only) |
| load_i | input | 1 | Capture curve_i into storage (idle only) |
| curve_i | input | 120 | Twelve 10-bit points, point i in bits [10i+9:10i] |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Downstream accepts the write |
| wr_addr_o | output | 8 | Register address |
| wr_data_o | output | 8 | Register data |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
The default curve is sent first. Its odd mix of high bits shows the packing path is wired to the right points. All-zero and all-ones curves then expose stuck bits. A curve whose high bits count 0,1,2,3 within each group, with distinct low bytes, tells apart swapped slot positions and swapped point indices. Random curves and random ready patterns, from always ready down to mostly stalled, test that writes hold steady under backpressure. Directed runs load and start in the middle of a burst and during the done cycle, then send another burst that must still carry the old curve. A run with load and start in the same cycle must carry the new curve.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

  localparam int unsigned DEF_NPTS = 12;
  localparam int unsigned DEF_PW   = 10;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_e;

  function automatic int unsigned default_point(input int unsigned idx);
    case (idx)
      0:  return 105;
      1:  return 315;
      2:  return 381;
      3:  return 431;
      4:  return 490;
      5:  return 537;
      6:  return 579;
      7:  return 686;
      8:  return 780;
      9:  return 837;
      10: return 880;
      default: return 1023;
    endcase
  endfunction

  function automatic logic [DEF_NPTS*DEF_PW-1:0] default_curve();
    logic [DEF_NPTS*DEF_PW-1:0] c;
    c = '0;
    for (int i = 0; i < DEF_NPTS; i++) begin
      c[i*DEF_PW +: DEF_PW] = DEF_PW'(default_point(i));
    end
    return c;
  endfunction

endpackage

// File: rtl/gamma_store.sv
module gamma_store #(
  parameter int unsigned NPTS = 12,
  parameter int unsigned PW   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_i,
  input  logic               load_i,
  input  logic [NPTS*PW-1:0] curve_i,
  output logic [NPTS*PW-1:0] curve_o
);

  localparam int unsigned CW = NPTS * PW;
  localparam logic [CW-1:0] RST_CURVE = CW'(gamma_pkg::default_curve());

  logic          ld_en;
  logic [CW-1:0] curve_d;
  logic [CW-1:0] curve_q;

  assign ld_en = load_i & idle_i;

  always_comb begin
    curve_d = curve_q;
    if (ld_en) curve_d = curve_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) curve_q <= RST_CURVE;
    else        curve_q <= curve_d;
  end

  assign curve_o = curve_q;

  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> $stable(curve_q)); // R10

  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && load_i) |=> (curve_q == $past(curve_i))); // R9

endmodule

// File: rtl/gamma_pack.sv
module gamma_pack #(
  parameter int unsigned NPTS    = 12,
  parameter int unsigned PW      = 10,
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 8,
  parameter int unsigned HI_BASE = 'h11,
  parameter int unsigned LO_BASE = 'h14,
  parameter int unsigned SW      = 4
) (
  input  logic [NPTS*PW-1:0] curve_i,
  input  logic [SW-1:0]      step_i,
  output logic [AW-1:0]      addr_o,
  output logic [DW-1:0]      data_o
);

  localparam int unsigned HB  = PW - DW;
  localparam int unsigned PER = DW / HB;
  localparam int unsigned NHI = NPTS / PER;

  wire [DW-1:0] hi_byte [NHI];
  wire [DW-1:0] lo_byte [NPTS];

  for (genvar g = 0; g < NHI; g++) begin : g_hi
    for (genvar s = 0; s < PER; s++) begin : g_slot
      assign hi_byte[g][DW-1-s*HB -: HB] = curve_i[(g*PER+s)*PW + DW +: HB];
    end
  end

  for (genvar p = 0; p < NPTS; p++) begin : g_lo
    assign lo_byte[p] = curve_i[p*PW +: DW];
  end

  always_comb begin
    addr_o = '0;
    data_o = '0;
    if (step_i < SW'(NHI)) begin
      addr_o = AW'(HI_BASE) + AW'(step_i);
      for (int k = 0; k < NHI; k++) begin
        if (step_i == SW'(k)) data_o = hi_byte[k];
      end
    end else begin
      addr_o = AW'(LO_BASE) + AW'(step_i - SW'(NHI));
      for (int k = 0; k < NPTS; k++) begin
        if (step_i == SW'(k + NHI)) data_o = lo_byte[k];
      end
    end
  end

endmodule

// File: rtl/gamma_seq.sv
module gamma_seq #(
  parameter int unsigned NWR = 15,
  parameter int unsigned SW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          wr_ready_i,
  output logic          wr_valid_o,
  output logic          done_o,
  output logic          idle_o,
  output logic [SW-1:0] step_o
);

  import gamma_pkg::*;

  localparam logic [SW-1:0] LAST = SW'(NWR - 1);

  seq_state_e    state_d, state_q;
  logic [SW-1:0] step_d, step_q;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          state_d = SQ_RUN;
          step_d  = '0;
        end
      end
      SQ_RUN: begin
        if (wr_ready_i) begin
          if (step_q == LAST) begin
            state_d = SQ_FIN;
            step_d  = '0;
          end else begin
            step_d = step_q + SW'(1);
          end
        end
      end
      SQ_FIN:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign wr_valid_o = (state_q == SQ_RUN);
  assign done_o     = (state_q == SQ_FIN);
  assign idle_o     = (state_q == SQ_IDLE);
  assign step_o     = step_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_valid_o && wr_ready_i)); // R8

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (step_q <= LAST)); // R6

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(step_q))); // R11

endmodule

// File: rtl/gamma_reg_packer.sv
module gamma_reg_packer #(
  parameter int unsigned NPTS    = gamma_pkg::DEF_NPTS,
  parameter int unsigned PW      = gamma_pkg::DEF_PW,
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 8,
  parameter int unsigned HI_BASE = 'h11,
  parameter int unsigned LO_BASE = 'h14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               load_i,
  input  logic [NPTS*PW-1:0] curve_i,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [AW-1:0]      wr_addr_o,
  output logic [DW-1:0]      wr_data_o,
  output logic               done_o
);

  localparam int unsigned HB  = PW - DW;
  localparam int unsigned PER = DW / HB;
  localparam int unsigned NHI = NPTS / PER;
  localparam int unsigned NWR = NHI + NPTS;
  localparam int unsigned SW  = $clog2(NWR);

  logic               idle;
  logic [SW-1:0]      step;
  logic [NPTS*PW-1:0] curve;

  gamma_store #(.NPTS(NPTS), .PW(PW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_i  (idle),
    .load_i  (load_i),
    .curve_i (curve_i),
    .curve_o (curve)
  );

  gamma_seq #(.NWR(NWR), .SW(SW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wr_ready_i (wr_ready_i),
    .wr_valid_o (wr_valid_o),
    .done_o     (done_o),
    .idle_o     (idle),
    .step_o     (step)
  );

  gamma_pack #(
    .NPTS(NPTS), .PW(PW), .DW(DW), .AW(AW),
    .HI_BASE(HI_BASE), .LO_BASE(LO_BASE), .SW(SW)
  ) u_pack (
    .curve_i (curve),
    .step_i  (step),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o)
  );

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R7

  AST_PACKED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && $past(wr_valid_o && wr_ready_i && (wr_addr_o >= AW'(LO_BASE))))
      |-> (wr_addr_o >= AW'(LO_BASE))); // R6

  AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_valid_o); // R8

endmodule

// File: tb/gamma_reg_packer_test.sv
`timescale 1ns/1ps
module gamma_reg_packer_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic         load_i;
  logic [119:0] curve_i;
  logic         wr_valid_o;
  logic         wr_ready_i;
  logic [7:0]   wr_addr_o;
  logic [7:0]   wr_data_o;
  logic         done_o;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  logic [119:0] model;

  always #4 clk = ~clk;

  gamma_reg_packer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
    .curve_i(curve_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o)
  );

  function automatic logic [119:0] make_curve(input int unsigned p [12]);
    logic [119:0] c;
    for (int i = 0; i < 12; i++) c[i*10 +: 10] = p[i][9:0];
    return c;
  endfunction

  function automatic logic [119:0] rand_curve();
    logic [119:0] c;
    for (int i = 0; i < 12; i++) c[i*10 +: 10] = 10'($urandom % 1024);
    return c;
  endfunction

  function automatic logic [7:0] exp_addr(input int n);
    return (n < 3) ? 8'(8'h11 + n) : 8'(8'h14 + n - 3);
  endfunction

  // R4: slot s of packed byte k takes bits [9:8] of point 4k+s, at shift 6-2s
  function automatic logic [7:0] exp_data(input logic [119:0] c, input int n);
    int unsigned v;
    v = 0;
    if (n < 3) begin
      for (int s = 0; s < 4; s++)
        v += ((c[(4*n+s)*10 +: 10] >> 8) & 3) << (6 - 2*s);
    end else begin
      v = c[(n-3)*10 +: 10] % 256;
    end
    return 8'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int unsigned act,
                       input int unsigned expv);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic load_idle(input logic [119:0] c);
    curve_i = c;
    load_i  = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    model  = c;   // R9
  endtask

  // Runs one burst; caller is at a negedge. disturb pokes load/start while busy.
  task automatic run_seq(input int pct, input bit disturb);
    int n = 0;
    int cyc = 0;
    bit stall = 0;
    logic [7:0] pa = 8'h0;
    logic [7:0] pd = 8'h0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    load_i  = 1'b0;
    while (n < 15 && cyc < 3000) begin
      cyc++;
      wr_ready_i = (($urandom % 100) < pct);
      if (disturb && (cyc == 2 || cyc == 5)) begin
        curve_i = rand_curve();
        load_i  = 1'b1;   // R10: ignored mid burst
        start_i = 1'b1;   // R11: ignored mid burst
      end else begin
        load_i  = 1'b0;
        start_i = 1'b0;
      end
      #1;
      if (!wr_valid_o) begin
        check(1'b0, "R6 valid dropped mid burst", wr_valid_o, 1);
      end else begin
        if (stall)
          check(wr_addr_o == pa && wr_data_o == pd, "R7 held write",
                {wr_addr_o, wr_data_o}, {pa, pd});
        check(wr_addr_o == exp_addr(n) && wr_data_o == exp_data(model, n),
              (n < 3) ? "R3 R4 packed write" : "R5 low byte write",
              {wr_addr_o, wr_data_o}, {exp_addr(n), exp_data(model, n)});
        if (wr_ready_i) n++;
      end
      pa = wr_addr_o;
      pd = wr_data_o;
      stall = wr_valid_o && !wr_ready_i;
      @(negedge clk);
    end
    load_i = 1'b0;
    start_i = 1'b0;
    #1;
    check(done_o && !wr_valid_o, "R8 done after last write",
          {done_o, wr_valid_o}, 2'b10);
    if (disturb) begin
      curve_i = rand_curve();
      load_i  = 1'b1;   // R10: ignored in done cycle
      start_i = 1'b1;   // R11: ignored in done cycle
    end
    @(negedge clk);
    load_i = 1'b0;
    start_i = 1'b0;
    #1;
    check(!done_o && !wr_valid_o, "R8 R11 single pulse, quiet after",
          {done_o, wr_valid_o}, 2'b00);
    @(negedge clk);
    #1;
    check(!wr_valid_o, "R11 no extra writes", wr_valid_o, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int unsigned dflt [12] = '{105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023};
    int unsigned ones [12] = '{default: 1023};
    int unsigned zer  [12] = '{default: 0};
    int unsigned cnt  [12];
    logic [119:0] nc;
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < 12; i++) cnt[i] = ((i % 4) << 8) | (i * 19 + 3);
    rst_n = 1'b0;
    start_i = 1'b0;
    load_i = 1'b0;
    wr_ready_i = 1'b0;
    curve_i = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!wr_valid_o && !done_o, "R1 reset outputs", {wr_valid_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!wr_valid_o && !done_o, "R1 after release", {wr_valid_o, done_o}, 0);
    @(negedge clk);

    model = make_curve(dflt);      // R2
    run_seq(100, 0);
    run_seq(35, 0);

    load_idle(make_curve(ones));   // R9 corner
    run_seq(100, 0);
    load_idle(make_curve(zer));
    run_seq(60, 0);
    load_idle(make_curve(cnt));    // R4 slot positions
    run_seq(100, 0);

    run_seq(50, 1);                // R10 R11 disturb
    run_seq(100, 0);               // old curve must remain

    nc = rand_curve();             // R12 load with start
    curve_i = nc;
    load_i = 1'b1;
    model = nc;
    run_seq(70, 0);

    for (int it = 0; it < 20; it++) begin
      load_idle(rand_curve());
      run_seq(20 + int'($urandom % 81), bit'($urandom % 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule